// File: doc/BRIEF.md
# Store-Load Pairing Tag Table

This block is a set-associative tag table, indexed by instruction address, that hands out pairing identifiers for memory instructions. At decode, a load or a store presents its program counter on the lookup port. If the table already holds an entry for that address, the block returns the value-slot index stored there. If it does not, the block claims a way in the addressed set, takes a fresh index from an internal round-robin slot allocator, records it and returns it with an allocation flag. Loads that miss allocate a slot in the same way as stores, so a load that is never written can still later read its slot.

A second port trains the table. When a load that was not renamed turns out to have read data from a renamed store, the load's address and the store's value index are written here. The load's next lookup then yields the store's index, and the two instructions share one slot. The value storage, confidence counters and recovery logic sit outside this block.

Top module: `sl_pair_table`

## Requirements
- R1: After reset every entry is invalid, so the first lookup of any address misses, and the slot allocator starts at index 0.
- R2: A lookup that misses drives `alloc_o`=1 and `hit_o`=0. It returns the allocator's current index on `vidx_o` and installs that index in the addressed set. There is no load/store distinction.
- R3: A lookup whose address matches a valid entry drives `hit_o`=1 and `alloc_o`=0, and returns that entry's recorded index.
- R4: The allocator hands out 0, 1, ..., VIDX_DEPTH-1, then wraps to 0. It advances only on a lookup miss.
- R5: The set is `pc[PC_LSB +: SET_W]`. All other address bits form the tag. An address in another set, or with another tag in the same set, does not hit.
- R6: On an install, the victim is the first invalid way (way 0 before way 1). If both ways are valid, the victim is the least recently used way. Every hit, install and training write makes the touched way most recently used.
- R7: A training write whose address is present overwrites that entry's index with `train_vidx_i`. It does not touch the allocator.
- R8: A training write whose address is absent installs it with `train_vidx_i`, evicting per R6. It does not advance the allocator.
- R9: If a training write and a lookup address the same set in one cycle, the training write is applied first. The lookup's result and its install reflect the trained set.
- R10: With `lookup_valid_i` low, `hit_o`, `alloc_o` and `vidx_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Decode-time probe request |
| lookup_pc_i | input | PC_W | Address of the probing instruction |
| hit_o | output | 1 | Probe found an entry |
| alloc_o | output | 1 | Probe missed and a new slot was allocated |
| vidx_o | output | VIDX_W | Value-slot index for the probe |
| train_valid_i | input | 1 | Training write request |
| train_pc_i | input | PC_W | Address of the load being trained |
| train_vidx_i | input | VIDX_W | Value-slot index of the producing store |

## Verification
The bench builds the table with 8 entries (four two-way sets), a 16-bit address and a 5-slot allocator. A handful of addresses is then enough to fill a set, force LRU evictions and wrap the allocator several times in a short run. Directed steps cover the eviction order, training hits and misses, and same-set train/lookup collisions. A random phase draws addresses from a small tag pool, so conflicts and simultaneous same-set traffic occur often and the behavioural model is compared against the outputs on every cycle.

// File: rtl/sl_pair_pkg.sv
package sl_pair_pkg;

  typedef enum logic [1:0] {
    RES_IDLE = 2'd0,
    RES_HIT  = 2'd1,
    RES_FILL = 2'd2
  } res_e;

  // invalid ways first, then the LRU way
  function automatic logic pick_victim(input logic [1:0] vld, input logic lru);
    if (!vld[0]) return 1'b0;
    if (!vld[1]) return 1'b1;
    return lru;
  endfunction

endpackage

// File: rtl/sl_vidx_alloc.sv
module sl_vidx_alloc #(
  parameter int DEPTH = 512,
  parameter int W     = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [W-1:0] idx_o
);

  localparam logic [W-1:0] LAST = W'(DEPTH - 1);

  logic [W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + W'(1);
  end

  assign idx_o = ptr_q;

  // R4
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= LAST);

  // R4
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_q));

endmodule

// File: rtl/sl_set_resolve.sv
module sl_set_resolve
  import sl_pair_pkg::*;
#(
  parameter int TAG_W  = 20,
  parameter int VIDX_W = 9
) (
  input  logic                        req_i,
  input  logic                        overwrite_i,
  input  logic [TAG_W-1:0]            tag_i,
  input  logic [VIDX_W-1:0]           new_vidx_i,
  input  logic [1:0]                  vld_i,
  input  logic [1:0][TAG_W-1:0]       tags_i,
  input  logic [1:0][VIDX_W-1:0]      vidxs_i,
  input  logic                        lru_i,
  output res_e                        res_o,
  output logic [VIDX_W-1:0]           vidx_o,
  output logic [1:0]                  vld_o,
  output logic [1:0][TAG_W-1:0]       tags_o,
  output logic [1:0][VIDX_W-1:0]      vidxs_o,
  output logic                        lru_o
);

  logic [1:0] way_hit;
  logic       any_hit;
  logic       way;

  for (genvar g = 0; g < 2; g++) begin : g_cmp
    assign way_hit[g] = vld_i[g] && (tags_i[g] == tag_i);
  end

  assign any_hit = |way_hit;
  assign way     = any_hit ? way_hit[1] : pick_victim(vld_i, lru_i);

  always_comb begin
    vld_o   = vld_i;
    tags_o  = tags_i;
    vidxs_o = vidxs_i;
    lru_o   = lru_i;
    res_o   = RES_IDLE;
    if (req_i) begin
      if (!any_hit) begin
        vld_o[way]   = 1'b1;
        tags_o[way]  = tag_i;
        vidxs_o[way] = new_vidx_i;
        res_o        = RES_FILL;
      end else begin
        if (overwrite_i) vidxs_o[way] = new_vidx_i;
        res_o = RES_HIT;
      end
      lru_o = ~way;
    end
    vidx_o = vidxs_o[way];
  end

endmodule

// File: rtl/sl_tag_store.sv
module sl_tag_store #(
  parameter int SETS   = 512,
  parameter int SET_W  = 9,
  parameter int TAG_W  = 20,
  parameter int VIDX_W = 9
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [SET_W-1:0]       ra_idx_i,
  output logic [1:0]             ra_vld_o,
  output logic [1:0][TAG_W-1:0]  ra_tags_o,
  output logic [1:0][VIDX_W-1:0] ra_vidxs_o,
  output logic                   ra_lru_o,
  input  logic [SET_W-1:0]       rb_idx_i,
  output logic [1:0]             rb_vld_o,
  output logic [1:0][TAG_W-1:0]  rb_tags_o,
  output logic [1:0][VIDX_W-1:0] rb_vidxs_o,
  output logic                   rb_lru_o,
  input  logic                   wa_en_i,
  input  logic [SET_W-1:0]       wa_idx_i,
  input  logic [1:0]             wa_vld_i,
  input  logic [1:0][TAG_W-1:0]  wa_tags_i,
  input  logic [1:0][VIDX_W-1:0] wa_vidxs_i,
  input  logic                   wa_lru_i,
  input  logic                   wb_en_i,
  input  logic [SET_W-1:0]       wb_idx_i,
  input  logic [1:0]             wb_vld_i,
  input  logic [1:0][TAG_W-1:0]  wb_tags_i,
  input  logic [1:0][VIDX_W-1:0] wb_vidxs_i,
  input  logic                   wb_lru_i
);

  logic [1:0]             vld_q  [SETS];
  logic                   lru_q  [SETS];
  logic [1:0][TAG_W-1:0]  tag_q  [SETS];
  logic [1:0][VIDX_W-1:0] vidx_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        lru_q[s] <= 1'b0;
      end
    end else begin
      if (wa_en_i) begin
        vld_q[wa_idx_i] <= wa_vld_i;
        lru_q[wa_idx_i] <= wa_lru_i;
      end
      if (wb_en_i) begin
        vld_q[wb_idx_i] <= wb_vld_i;
        lru_q[wb_idx_i] <= wb_lru_i;
      end
    end
  end

  // payload carries no reset; valid bits gate it
  always_ff @(posedge clk_i) begin
    if (wa_en_i) begin
      tag_q[wa_idx_i]  <= wa_tags_i;
      vidx_q[wa_idx_i] <= wa_vidxs_i;
    end
    if (wb_en_i) begin
      tag_q[wb_idx_i]  <= wb_tags_i;
      vidx_q[wb_idx_i] <= wb_vidxs_i;
    end
  end

  assign ra_vld_o   = vld_q[ra_idx_i];
  assign ra_tags_o  = tag_q[ra_idx_i];
  assign ra_vidxs_o = vidx_q[ra_idx_i];
  assign ra_lru_o   = lru_q[ra_idx_i];
  assign rb_vld_o   = vld_q[rb_idx_i];
  assign rb_tags_o  = tag_q[rb_idx_i];
  assign rb_vidxs_o = vidx_q[rb_idx_i];
  assign rb_lru_o   = lru_q[rb_idx_i];

  // R9
  no_dual_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wa_en_i && wb_en_i) |-> (wa_idx_i != wb_idx_i));

endmodule

// File: rtl/sl_pair_table.sv
module sl_pair_table
  import sl_pair_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int PC_LSB     = 2,
  parameter int ENTRIES    = 1024,
  parameter int VIDX_DEPTH = 512,
  localparam int VIDX_W    = (VIDX_DEPTH > 1) ? $clog2(VIDX_DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_valid_i,
  input  logic [PC_W-1:0]   lookup_pc_i,
  output logic              hit_o,
  output logic              alloc_o,
  output logic [VIDX_W-1:0] vidx_o,
  input  logic              train_valid_i,
  input  logic [PC_W-1:0]   train_pc_i,
  input  logic [VIDX_W-1:0] train_vidx_i
);

  localparam int WAYS  = 2;
  localparam int SETS  = ENTRIES / WAYS;
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W = PC_W - SET_W;

  typedef logic [TAG_W-1:0] tag_t;

  function automatic tag_t tag_of(input logic [PC_W-1:0] pc);
    return {pc[PC_W-1:PC_LSB+SET_W], pc[PC_LSB-1:0]};
  endfunction

  logic [SET_W-1:0] l_set, t_set;
  tag_t             l_tag, t_tag;
  logic             same_set;

  assign l_set    = lookup_pc_i[PC_LSB +: SET_W];
  assign t_set    = train_pc_i[PC_LSB +: SET_W];
  assign l_tag    = tag_of(lookup_pc_i);
  assign t_tag    = tag_of(train_pc_i);
  assign same_set = train_valid_i && lookup_valid_i && (t_set == l_set);

  // stored set views
  logic [1:0]             ta_vld,  lb_vld;
  logic [1:0][TAG_W-1:0]  ta_tags, lb_tags;
  logic [1:0][VIDX_W-1:0] ta_vx,   lb_vx;
  logic                   ta_lru,  lb_lru;

  // after training
  res_e                   t_res;
  logic [VIDX_W-1:0]      t_vidx;
  logic [1:0]             tn_vld;
  logic [1:0][TAG_W-1:0]  tn_tags;
  logic [1:0][VIDX_W-1:0] tn_vx;
  logic                   tn_lru;

  // lookup base and result
  logic [1:0]             lbase_vld;
  logic [1:0][TAG_W-1:0]  lbase_tags;
  logic [1:0][VIDX_W-1:0] lbase_vx;
  logic                   lbase_lru;
  res_e                   l_res;
  logic [VIDX_W-1:0]      l_vidx;
  logic [1:0]             ln_vld;
  logic [1:0][TAG_W-1:0]  ln_tags;
  logic [1:0][VIDX_W-1:0] ln_vx;
  logic                   ln_lru;

  logic [VIDX_W-1:0]      fresh_idx;

  sl_tag_store #(
    .SETS(SETS), .SET_W(SET_W), .TAG_W(TAG_W), .VIDX_W(VIDX_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ra_idx_i   (t_set),
    .ra_vld_o   (ta_vld),
    .ra_tags_o  (ta_tags),
    .ra_vidxs_o (ta_vx),
    .ra_lru_o   (ta_lru),
    .rb_idx_i   (l_set),
    .rb_vld_o   (lb_vld),
    .rb_tags_o  (lb_tags),
    .rb_vidxs_o (lb_vx),
    .rb_lru_o   (lb_lru),
    .wa_en_i    (train_valid_i && !same_set),
    .wa_idx_i   (t_set),
    .wa_vld_i   (tn_vld),
    .wa_tags_i  (tn_tags),
    .wa_vidxs_i (tn_vx),
    .wa_lru_i   (tn_lru),
    .wb_en_i    (lookup_valid_i),
    .wb_idx_i   (l_set),
    .wb_vld_i   (ln_vld),
    .wb_tags_i  (ln_tags),
    .wb_vidxs_i (ln_vx),
    .wb_lru_i   (ln_lru)
  );

  sl_set_resolve #(.TAG_W(TAG_W), .VIDX_W(VIDX_W)) u_train_res (
    .req_i       (train_valid_i),
    .overwrite_i (1'b1),
    .tag_i       (t_tag),
    .new_vidx_i  (train_vidx_i),
    .vld_i       (ta_vld),
    .tags_i      (ta_tags),
    .vidxs_i     (ta_vx),
    .lru_i       (ta_lru),
    .res_o       (t_res),
    .vidx_o      (t_vidx),
    .vld_o       (tn_vld),
    .tags_o      (tn_tags),
    .vidxs_o     (tn_vx),
    .lru_o       (tn_lru)
  );

  // same-set training wins and is seen by the lookup
  assign lbase_vld  = same_set ? tn_vld  : lb_vld;
  assign lbase_tags = same_set ? tn_tags : lb_tags;
  assign lbase_vx   = same_set ? tn_vx   : lb_vx;
  assign lbase_lru  = same_set ? tn_lru  : lb_lru;

  sl_set_resolve #(.TAG_W(TAG_W), .VIDX_W(VIDX_W)) u_look_res (
    .req_i       (lookup_valid_i),
    .overwrite_i (1'b0),
    .tag_i       (l_tag),
    .new_vidx_i  (fresh_idx),
    .vld_i       (lbase_vld),
    .tags_i      (lbase_tags),
    .vidxs_i     (lbase_vx),
    .lru_i       (lbase_lru),
    .res_o       (l_res),
    .vidx_o      (l_vidx),
    .vld_o       (ln_vld),
    .tags_o      (ln_tags),
    .vidxs_o     (ln_vx),
    .lru_o       (ln_lru)
  );

  sl_vidx_alloc #(.DEPTH(VIDX_DEPTH), .W(VIDX_W)) u_alloc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (alloc_o),
    .idx_o  (fresh_idx)
  );

  assign hit_o   = (l_res == RES_HIT);
  assign alloc_o = (l_res == RES_FILL);
  assign vidx_o  = lookup_valid_i ? l_vidx : '0;

  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |-> (!hit_o && !alloc_o && vidx_o == '0));

  // R2
  one_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |-> (hit_o != alloc_o));

  // R3
  repeat_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && lookup_valid_i && !train_valid_i && $past(lookup_valid_i)
     && !$past(train_valid_i) && lookup_pc_i == $past(lookup_pc_i))
    |-> (hit_o && vidx_o == $past(vidx_o)));

  // R7
  train_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (train_valid_i && !lookup_valid_i) |-> !alloc_o);

endmodule

// File: tb/sl_pair_table_tb.sv
module sl_pair_table_tb;

  localparam int PC_W  = 16;
  localparam int LSB   = 2;
  localparam int ENT   = 8;
  localparam int DEPTH = 5;
  localparam int VW    = 3;
  localparam int NSET  = ENT / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lv = 1'b0, tv = 1'b0;
  logic [PC_W-1:0] lpc = '0, tpc = '0;
  logic [VW-1:0] tvx = '0;
  logic          hit, alc;
  logic [VW-1:0] vx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sl_pair_table #(.PC_W(PC_W), .PC_LSB(LSB), .ENTRIES(ENT), .VIDX_DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lookup_valid_i(lv), .lookup_pc_i(lpc),
    .hit_o(hit), .alloc_o(alc), .vidx_o(vx),
    .train_valid_i(tv), .train_pc_i(tpc), .train_vidx_i(tvx)
  );

  // behavioural model
  bit m_v   [NSET][2];
  int m_pc  [NSET][2];
  int m_vx  [NSET][2];
  int m_lru [NSET];
  int m_ptr;
  bit e_hit, e_alc;
  int e_vx;

  function automatic int pc_of(int tag, int set);
    return (tag << 4) | (set << LSB);
  endfunction

  function automatic int set_of(int pc);
    return (pc >> LSB) % NSET;
  endfunction

  function automatic int find_way(int s, int pc);
    for (int w = 0; w < 2; w++) if (m_v[s][w] && m_pc[s][w] == pc) return w;
    return -1;
  endfunction

  function automatic int victim(int s);
    if (!m_v[s][0]) return 0;
    if (!m_v[s][1]) return 1;
    return m_lru[s];
  endfunction

  task automatic model_reset();
    for (int s = 0; s < NSET; s++) begin
      m_v[s][0] = 0; m_v[s][1] = 0; m_lru[s] = 0;
    end
    m_ptr = 0;
  endtask

  task automatic model_step(bit l, int lp, bit t, int tp, int tx);
    int s, w;
    e_hit = 0; e_alc = 0; e_vx = 0;
    if (t) begin
      s = set_of(tp);
      w = find_way(s, tp);
      if (w < 0) begin
        w = victim(s); m_v[s][w] = 1; m_pc[s][w] = tp;
      end
      m_vx[s][w] = tx;
      m_lru[s] = 1 - w;
    end
    if (l) begin
      s = set_of(lp);
      w = find_way(s, lp);
      if (w >= 0) begin
        e_hit = 1; e_vx = m_vx[s][w];
      end else begin
        w = victim(s); m_v[s][w] = 1; m_pc[s][w] = lp; m_vx[s][w] = m_ptr;
        e_alc = 1; e_vx = m_ptr;
        m_ptr = (m_ptr + 1) % DEPTH;
      end
      m_lru[s] = 1 - w;
    end
  endtask

  task automatic compare(string req);
    checks++;
    if (hit !== e_hit || alc !== e_alc || int'(vx) !== e_vx) begin
      errors++;
      $display("FAIL %s: hit=%0b alloc=%0b vidx=%0d expected hit=%0b alloc=%0b vidx=%0d",
               req, hit, alc, vx, e_hit, e_alc, e_vx);
    end
  endtask

  task automatic step(bit l, int lp, bit t, int tp, int tx, string req);
    @(negedge clk);
    lv = l; lpc = PC_W'(lp); tv = t; tpc = PC_W'(tp); tvx = VW'(tx);
    #1;
    model_step(l, lp, t, tp, tx);
    compare(req);
  endtask

  task automatic look(int pc, string req);
    step(1, pc, 0, 0, 0, req);
  endtask

  initial begin
    int a, b, c, d;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    e_hit = 0; e_alc = 0; e_vx = 0;
    compare("R10 during reset");
    @(negedge clk);
    rst_n = 1'b1;

    a = pc_of(1, 0); b = pc_of(2, 0); c = pc_of(3, 0); d = pc_of(1, 1);
    look(a, "R1 first lookup misses, index 0");
    look(a, "R3 repeat lookup hits");
    look(b, "R2 miss fills way 1");
    look(a, "R3 hit refreshes LRU");
    look(c, "R6 evicts LRU way");
    look(b, "R6 evicted address misses");
    look(a, "R4 allocator reaches last index");
    look(d, "R5 same tag other set misses, R4 wrap");
    step(0, 0, 0, 0, 0, "R10 idle outputs zero");
    step(0, 0, 1, b, 6, "R7 train existing entry");
    look(b, "R7 trained index returned");
    step(0, 0, 1, pc_of(4, 2), 3, "R8 train absent entry");
    look(pc_of(4, 2), "R8 trained install hits without alloc");
    step(1, pc_of(5, 3), 1, pc_of(5, 3), 1, "R9 same address same cycle");
    step(1, pc_of(6, 3), 1, pc_of(7, 3), 4, "R9 same set different address");
    look(pc_of(7, 3), "R9 trained entry kept");
    look(pc_of(5, 3), "R6 LRU after collision");

    for (int i = 0; i < 400; i++) begin
      int r = $urandom;
      step(r[0], pc_of(int'(r[3:2]), int'(r[5:4])),
           r[6] & r[7], pc_of(int'(r[9:8]), int'(r[11:10])),
           int'(r[14:12]), "R6 random traffic");
    end
    step(0, 0, 0, 0, 0, "R10 final idle");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule